// File: doc/BRIEF.md
# Sequential Configuration Register Serial Slave

This block is the control port of a clock generator. It holds a small bank of 8-bit configuration registers and lets a two-wire serial master (SCL clock, SDA open-drain data) fill or dump that bank. The registers are not addressed one by one. A write always starts filling at register 0 and moves up one register per byte. A read always returns a byte count first and then the bank from register 0 upward. The register contents are brought out in parallel on `cfg_o` so that the frequency, spread and output-enable logic next to this block can use them directly.

SCL and SDA are sampled by a fast system clock through two-flop synchronizers. Start and stop conditions are recognised as an SDA edge while SCL is high. The slave never stretches SCL. The serial bus has no way to stall, so neither side has a valid/ready handshake and no back-pressure exists: the system clock only has to be fast enough that each SCL phase spans several system cycles, which is always true at 100 kbit/s. The slave pulls SDA low by raising `sda_oe_o`. The pad or the bench forms the wired-AND line from it.

Top module: `cfg_serial_slave`

## Requirements
- R1: After reset, `cfg_o` holds `RESET_VALUES` (register i in bits [8i+7:8i]) and `sda_oe_o` is 0.
- R2: The slave acknowledges its 7-bit address `DEV_ADDR` (default 0x69, which is 0xD2 as a write byte and 0xD3 as a read byte; bit 0 of the address byte is 1 for read). It does this by driving SDA low during the ninth clock.
- R3: An address byte with any other 7-bit address is not acknowledged. Until the next start condition, the slave then never drives SDA and changes no register.
- R4: In a write, the first two bytes after the address are acknowledged and never stored, whatever their values. The second byte does not limit how many data bytes are accepted.
- R5: Write data bytes are received MSB first and stored into registers 0, 1, 2, … in increasing order. Each byte is acknowledged.
- R6: A write may end with a stop after any complete byte. Registers not yet reached keep their previous values.
- R7: Data bytes beyond register `NUM_REGS`-1 are acknowledged and discarded.
- R8: In a read, the first byte sent (MSB first) equals `NUM_REGS`. It is followed by registers 0, 1, … for as long as the master acknowledges. A read changes no register.
- R9: After the last register, the slave sends 0xFF for every further acknowledged byte. After a NACK from the master, it stops driving SDA, and SDA is released after the stop.
- R10: A start condition in the middle of a byte abandons the transfer, and the next byte is taken as an address.
- R11: `sda_oe_o` changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset, loads the defaults |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low (acknowledge or read data 0) |
| cfg_o | output | NUM_REGS*8 | Register bank, register i in bits [8i+7:8i] |

## Verification
The main write path is driven from a table of writes of 0, 1, 3 and 7 data bytes. The entries use different command and count values, including a count of zero that is followed by data. Each write is then read back in full. This separates correct ordering and partial updates from a slave that honours the count byte or stores the header bytes. Directed sequences add a write of more bytes than the bank holds, a foreign address followed by data-like traffic, and a start condition cut into the middle of a byte. A read that runs past the last register is also used. Together they tell the overflow discard, the ignore state, the restart of the byte engine and the 0xFF filler apart from ordinary transfers.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_RX,
    ST_TX,
    ST_MACK,
    ST_IGNORE
  } cfgs_state_e;
endpackage

// File: rtl/cfgs_sync.sv
module cfgs_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d[g]};
    end
    assign q[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/cfgs_bus_events.sv
module cfgs_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/cfgs_regbank.sv
module cfgs_regbank #(
  parameter int                     NUM_REGS     = 7,
  parameter int                     IDXW         = 3,
  parameter logic [NUM_REGS*8-1:0]  RESET_VALUES = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IDXW-1:0]       wr_idx,
  input  logic [7:0]            wr_data,
  input  logic [IDXW-1:0]       rd_idx,
  output logic [7:0]            rd_data,
  output logic [NUM_REGS*8-1:0] cfg_flat
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [7:0] r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               r <= RESET_VALUES[g*8 +: 8];
      else if (wr_en && wr_idx == IDXW'(g))     r <= wr_data;
    end
    assign cfg_flat[g*8 +: 8] = r;
  end

  // Index past the bank reads as all ones (filler byte).
  always_comb begin
    rd_data = 8'hFF;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_idx == IDXW'(i)) rd_data = cfg_flat[i*8 +: 8];
    end
  end
endmodule

// File: rtl/cfg_serial_slave.sv
module cfg_serial_slave
  import cfgs_pkg::*;
#(
  parameter int                    NUM_REGS     = 7,
  parameter logic [6:0]            DEV_ADDR     = 7'h69,
  parameter logic [NUM_REGS*8-1:0] RESET_VALUES = 56'h00_06_00_FF_FF_00_3C
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  output logic [NUM_REGS*8-1:0] cfg_o
);
  localparam int             IDXW      = $clog2(NUM_REGS + 1);
  localparam int             CW        = $clog2(NUM_REGS + 3);
  localparam logic [CW-1:0]  CNT_DATA0 = CW'(2);
  localparam logic [CW-1:0]  CNT_MAX   = CW'(NUM_REGS + 2);
  localparam logic [IDXW-1:0] IDX_END  = IDXW'(NUM_REGS);

  logic [1:0] raw_bus, synced;
  logic       scl_s, sda_s;
  logic       scl_rise, scl_fall, start_det, stop_det;

  assign raw_bus = {scl_i, sda_i};

  cfgs_sync #(.W(2), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_bus),
    .q     (synced)
  );
  assign scl_s = synced[1];
  assign sda_s = synced[0];

  cfgs_bus_events u_events (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  cfgs_state_e     state;
  logic [3:0]      bit_cnt;
  logic [7:0]      rx_sr;
  logic [7:0]      tx_sr;
  logic            is_read;
  logic            ack_drv;
  logic [CW-1:0]   byte_cnt;
  logic [IDXW-1:0] rd_idx;
  logic [7:0]      rd_data;
  logic            wr_en;
  logic [IDXW-1:0] wr_idx;

  // A received data byte commits on the SCL fall that closes its 8th bit.
  assign wr_en  = (state == ST_RX) && scl_fall && (bit_cnt == 4'd8) &&
                  (byte_cnt >= CNT_DATA0) && (byte_cnt < CNT_MAX);
  assign wr_idx = IDXW'(byte_cnt - CNT_DATA0);

  cfgs_regbank #(
    .NUM_REGS     (NUM_REGS),
    .IDXW         (IDXW),
    .RESET_VALUES (RESET_VALUES)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (rx_sr),
    .rd_idx   (rd_idx),
    .rd_data  (rd_data),
    .cfg_flat (cfg_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      rx_sr    <= '0;
      tx_sr    <= '1;
      is_read  <= 1'b0;
      ack_drv  <= 1'b0;
      byte_cnt <= '0;
      rd_idx   <= '0;
    end else if (start_det) begin
      state    <= ST_ADDR;
      bit_cnt  <= '0;
      ack_drv  <= 1'b0;
      byte_cnt <= '0;
      rd_idx   <= '0;
      tx_sr    <= '1;
    end else if (stop_det) begin
      state   <= ST_IDLE;
      ack_drv <= 1'b0;
      tx_sr   <= '1;
    end else begin
      unique case (state)
        ST_ADDR, ST_RX: begin
          if (scl_rise && bit_cnt != 4'd8) begin
            rx_sr   <= {rx_sr[6:0], sda_s};
            bit_cnt <= bit_cnt + 4'd1;
          end
          if (scl_fall && bit_cnt == 4'd8) begin
            bit_cnt <= '0;
            if (state == ST_ADDR) begin
              if (rx_sr[7:1] == DEV_ADDR) begin
                state   <= ST_ACK;
                ack_drv <= 1'b1;
                is_read <= rx_sr[0];
                tx_sr   <= 8'(NUM_REGS);
              end else begin
                state <= ST_IGNORE;
              end
            end else begin
              state   <= ST_ACK;
              ack_drv <= 1'b1;
              if (byte_cnt != CNT_MAX) byte_cnt <= byte_cnt + 1'b1;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            ack_drv <= 1'b0;
            bit_cnt <= '0;
            state   <= is_read ? ST_TX : ST_RX;
          end
        end
        ST_TX: begin
          if (scl_rise) bit_cnt <= bit_cnt + 4'd1;
          if (scl_fall) begin
            if (bit_cnt == 4'd8) begin
              state   <= ST_MACK;
              bit_cnt <= '0;
              tx_sr   <= '1;
            end else begin
              tx_sr <= {tx_sr[6:0], 1'b1};
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            if (!sda_s) begin
              tx_sr <= rd_data;
              if (rd_idx != IDX_END) rd_idx <= rd_idx + 1'b1;
            end else begin
              state <= ST_IGNORE;
            end
          end else if (scl_fall) begin
            state <= ST_TX;
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = ((state == ST_ACK) && ack_drv) ||
                    ((state == ST_TX) && !tx_sr[7]);
endmodule

// File: rtl/cfgs_checker.sv
module cfgs_checker
  import cfgs_pkg::*;
#(
  parameter int CFG_W = 56
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_s,
  input logic              stop_det,
  input logic              sda_oe,
  input cfgs_state_e       state,
  input logic              wr_en,
  input logic              is_read,
  input logic [CFG_W-1:0]  cfg
);
  p_oe_moves_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  p_release_after_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  p_ignore_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IGNORE) |-> (!sda_oe && !wr_en));

  p_no_store_on_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !is_read);

  p_bank_needs_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg) |-> $past(wr_en));
endmodule

bind cfg_serial_slave cfgs_checker #(.CFG_W(NUM_REGS*8)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_s    (scl_s),
  .stop_det (stop_det),
  .sda_oe   (sda_oe_o),
  .state    (state),
  .wr_en    (wr_en),
  .is_read  (is_read),
  .cfg      (cfg_o)
);

// File: tb/cfg_serial_slave_tb.sv
module cfg_serial_slave_tb;
  localparam int          CLK_PERIOD = 10;
  localparam int          QTR        = 12;
  localparam int          NREG       = 7;
  localparam logic [55:0] DEFAULTS   = 56'h00_06_00_FF_FF_00_3C;

  // Table: header {command, count}, number of data bytes, data (byte k at [8k+:8]).
  localparam int           NV = 4;
  localparam logic [15:0]  VHDR [NV] = '{16'h00_01, 16'hFF_00, 16'h5A_07, 16'hC3_3F};
  localparam int           VN   [NV] = '{1, 3, 7, 0};
  localparam logic [63:0]  VD   [NV] = '{64'h0000_0000_0000_00A1,
                                         64'h0000_0000_0033_2211,
                                         64'h00F7_E6D5_C4B3_A291,
                                         64'hDEAD_BEEF_DEAD_BEEF};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        sda_oe_o;
  logic [55:0] cfg_o;
  logic        sda_bus;

  int n_checks = 0;
  int n_fail   = 0;
  int oe_viol  = 0;
  logic oe_prev = 1'b0;
  logic watch_oe = 1'b0;
  logic oe_seen  = 1'b0;
  logic [55:0] model;

  assign sda_bus = sda_m & ~sda_oe_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_serial_slave #(
    .NUM_REGS     (NREG),
    .DEV_ADDR     (7'h69),
    .RESET_VALUES (DEFAULTS)
  ) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_m),
    .sda_i    (sda_bus),
    .sda_oe_o (sda_oe_o),
    .cfg_o    (cfg_o)
  );

  always @(negedge clk) begin
    if (rst_n && (sda_oe_o != oe_prev) && scl_m) oe_viol++;
    oe_prev = sda_oe_o;
    if (watch_oe && sda_oe_o) oe_seen = 1'b1;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_q();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_q();
    scl_m = 1'b1; wait_q();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b1; wait_q();
    sda_m = 1'b1; wait_q();
  endtask

  task automatic clock_bit(input logic b);
    sda_m = b; wait_q();
    scl_m = 1'b1; wait_q(); wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) clock_bit(b[i]);
    sda_m = 1'b1; wait_q();
    scl_m = 1'b1; wait_q();
    acked = ~sda_bus;
    wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wait_q();
      scl_m = 1'b1; wait_q();
      b[i] = sda_bus;
      wait_q();
      scl_m = 1'b0;
    end
    wait_q();
    sda_m = ~give_ack; wait_q();
    scl_m = 1'b1; wait_q(); wait_q();
    scl_m = 1'b0; wait_q();
    sda_m = 1'b1;
  endtask

  task automatic write_seq(input logic [15:0] hdr, input int n, input logic [79:0] data,
                           output logic addr_ack, output logic all_ack);
    logic a;
    bus_start();
    send_byte(8'hD2, addr_ack);
    all_ack = addr_ack;
    send_byte(hdr[15:8], a); all_ack &= a;
    send_byte(hdr[7:0], a);  all_ack &= a;
    for (int k = 0; k < n; k++) begin
      send_byte(data[k*8 +: 8], a);
      all_ack &= a;
    end
    bus_stop();
  endtask

  task automatic read_all(output logic addr_ack, output logic [7:0] cnt,
                          output logic [55:0] regs, output logic [7:0] extra);
    logic [7:0] b;
    bus_start();
    send_byte(8'hD3, addr_ack);
    recv_byte(1'b1, cnt);
    for (int k = 0; k < NREG; k++) begin
      recv_byte(1'b1, b);
      regs[k*8 +: 8] = b;
    end
    recv_byte(1'b0, extra);
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic        aa, al;
    logic [7:0]  cnt, extra;
    logic [55:0] regs;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: reset state
    chk(cfg_o == DEFAULTS, "R1", 64'(cfg_o), 64'(DEFAULTS));
    chk(sda_oe_o == 1'b0, "R1", 64'(sda_oe_o), 64'd0);
    model = DEFAULTS;

    // Table walk: write, compare bank, read back
    for (int i = 0; i < NV; i++) begin
      write_seq(VHDR[i], VN[i], {16'h0, VD[i]}, aa, al);
      for (int k = 0; k < VN[i] && k < NREG; k++) model[k*8 +: 8] = VD[i][k*8 +: 8];
      chk(aa, "R2", 64'(aa), 64'd1);
      chk(al, "R5", 64'(al), 64'd1);
      chk(cfg_o == model, (VN[i] == 0) ? "R4" : "R5/R6", 64'(cfg_o), 64'(model));
      read_all(aa, cnt, regs, extra);
      chk(aa, "R2", 64'(aa), 64'd1);
      chk(regs == model, "R8", 64'(regs), 64'(model));
    end

    // R8/R9: count byte, filler after last register, release after stop
    read_all(aa, cnt, regs, extra);
    chk(cnt == 8'(NREG), "R8", 64'(cnt), 64'(NREG));
    chk(extra == 8'hFF, "R9", 64'(extra), 64'hFF);
    chk(cfg_o == model, "R8", 64'(cfg_o), 64'(model));
    chk(sda_oe_o == 1'b0, "R9", 64'(sda_oe_o), 64'd0);

    // R7: more data bytes than registers
    write_seq(16'h1234, 9, 80'h9988_7766_5544_3322_1100, aa, al);
    model = 56'h66_5544_3322_1100;
    chk(al, "R7", 64'(al), 64'd1);
    chk(cfg_o == model, "R7", 64'(cfg_o), 64'(model));

    // R3: foreign address, then traffic that would be a write
    watch_oe = 1'b1;
    bus_start();
    send_byte(8'hA4, aa);
    chk(!aa, "R3", 64'(aa), 64'd0);
    send_byte(8'h00, al);
    send_byte(8'h00, al);
    send_byte(8'h5C, al);
    send_byte(8'hD2, al);
    bus_stop();
    watch_oe = 1'b0;
    chk(!oe_seen, "R3", 64'(oe_seen), 64'd0);
    chk(cfg_o == model, "R3", 64'(cfg_o), 64'(model));

    // R10: start condition cut into a data byte
    bus_start();
    send_byte(8'hD2, aa);
    send_byte(8'h00, aa);
    send_byte(8'h00, aa);
    clock_bit(1'b1); clock_bit(1'b0); clock_bit(1'b1);
    bus_start();
    send_byte(8'hD2, aa);
    chk(aa, "R10", 64'(aa), 64'd1);
    send_byte(8'h00, al);
    send_byte(8'h00, al);
    send_byte(8'h77, al);
    bus_stop();
    model[7:0] = 8'h77;
    chk(cfg_o == model, "R10", 64'(cfg_o), 64'(model));

    // R11: drive changes only in SCL low phases
    chk(oe_viol == 0, "R11", 64'(oe_viol), 64'd0);

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule